// File: doc/BRIEF.md
# Cascaded Multi-Key Flash Lock Controller

This block guards the program/erase control register of an on-chip flash array behind three nested locks. One lock protects the control register itself, one protects the program memory and one protects the option area. Each lock opens only when its own key register receives a fixed pair of 32-bit words in the right order. The program and option locks can be opened only after the control lock is open. Any wrong or out-of-order key word shuts every lock and keeps them shut until reset. Software can close any lock again at any time by writing ones into the lock bits of the control register.

Once the control and program locks are open, software selects erase mode and program mode in the control register. A page erase then starts when software writes a zero word to any address inside the target page. The block raises a one-cycle erase request that carries the page index, and holds a busy flag for a fixed number of cycles. Software polls that flag in the status register before it continues. A simple single-cycle bus slave reaches the register space and the array space. The array contents themselves are outside this block.

Top module: `flk_lock_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000_0007: control lock (bit 0), program lock (bit 1) and option lock (bit 2) are all set, the program-mode bit 3 and the erase-mode bit 9 are clear, and busy is low.
- R2: Writing 0x89ABCDEF and then 0x02030405 to the control key register at offset 0x0C clears control lock bit 0.
- R3: Writing 0x8C9DAEBF and then 0x13141516 to the program key register at offset 0x10 clears program lock bit 1. This works only while bit 0 is clear; a write to this register while bit 0 is set counts as a wrong sequence.
- R4: Writing 0xFBEAD9C8 and then 0x24252627 to the option key register at offset 0x14 clears option lock bit 2, under the same condition on bit 0 as R3.
- R5: A key word that does not match the expected word of its step sets all three locks. After that, every key write is ignored until reset, so even a correct pair leaves the locks set.
- R6: In a write to the control register at offset 0x04, a one in bit 0 sets all three locks, and a one in bit 1 or bit 2 sets that lock alone. A zero never clears a lock bit.
- R7: Bit 3 (program mode) and bit 9 (erase mode) take the written value only if bit 0 was clear before the write and busy is low. Otherwise they keep their value.
- R8: A write of the word zero to array space starts an erase when bits 3 and 9 are set, bit 1 is clear and busy is low. In the cycle after that write, erase_start pulses high for exactly one cycle, and erase_page carries the address bits above the page offset.
- R9: Any other write to array space starts no erase. This covers a nonzero word, a missing mode bit, a set program lock, and a write while busy.
- R10: Busy is high for exactly ERASE_CYCLES cycles, starting in the cycle after the accepted write. It appears both on the busy pin and in bit 0 of the status register at offset 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_mem | input | 1 | 1 selects array space, 0 selects register space |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; zero for key registers and unmapped offsets |
| erase_start | output | 1 | One-cycle request to erase a page |
| erase_page | output | PAGE_W | Index of the page to erase |
| busy | output | 1 | Erase in progress |

## Verification
The bench targets the freeze path in two ways: a bad second key word, and a program key sent while the control lock is still set. After each, a correct pair follows. A design that forgot the freeze, or that checked the hierarchy only at unlock time, would open a lock at that point. It writes mode bits while locked and while busy. A design that guarded them wrongly would show changed bits on readback. It checks that zero writes never clear a lock and that bit 0 closes all three locks. It sends array writes that are nonzero, that hit a set program lock, or that arrive during busy. A design with a loose erase gate would pulse erase_start for these. Finally it counts busy cycles exactly, which exposes off-by-one errors in the timer.

// File: rtl/flk_pkg.sv
package flk_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_LOCKS = 3;
    localparam int OFS_W     = 5;

    localparam int LK_CTRL   = 0;
    localparam int LK_PROG   = 1;
    localparam int LK_OPT    = 2;
    localparam int BIT_PROG  = 3;
    localparam int BIT_ERASE = 9;
    localparam int BIT_BUSY  = 0;

    localparam logic [OFS_W-1:0] OFS_CTRL     = 5'h04;
    localparam logic [OFS_W-1:0] OFS_KEY_CTRL = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_KEY_PROG = 5'h10;
    localparam logic [OFS_W-1:0] OFS_KEY_OPT  = 5'h14;
    localparam logic [OFS_W-1:0] OFS_STAT     = 5'h18;

    typedef enum logic { KS_IDLE, KS_HALF } key_stage_e;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_KEY0, SEL_KEY1, SEL_KEY2, SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_LOCKS-1:0] locks;
        logic                 prog;
        logic                 erase;
        logic                 frozen;
    } ctrl_state_t;

    function automatic reg_sel_e decode_reg(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_CTRL:     return SEL_CTRL;
            OFS_KEY_CTRL: return SEL_KEY0;
            OFS_KEY_PROG: return SEL_KEY1;
            OFS_KEY_OPT:  return SEL_KEY2;
            OFS_STAT:     return SEL_STAT;
            default:      return SEL_NONE;
        endcase
    endfunction

    function automatic reg_sel_e key_sel(input int idx);
        case (idx)
            0:       return SEL_KEY0;
            1:       return SEL_KEY1;
            default: return SEL_KEY2;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] key_first(input int idx);
        case (idx)
            0:       return 32'h89AB_CDEF;
            1:       return 32'h8C9D_AEBF;
            default: return 32'hFBEA_D9C8;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] key_second(input int idx);
        case (idx)
            0:       return 32'h0203_0405;
            1:       return 32'h1314_1516;
            default: return 32'h2425_2627;
        endcase
    endfunction

endpackage

// File: rtl/flk_key_seq.sv
module flk_key_seq
    import flk_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY_A = '0,
    parameter logic [DATA_W-1:0] KEY_B = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              allowed,
    input  logic              frozen,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlock,
    output logic              bad
);

    key_stage_e stage_q, stage_d;

    always_comb begin
        stage_d = stage_q;
        unlock  = 1'b0;
        bad     = 1'b0;
        if (frozen) begin
            stage_d = KS_IDLE;
        end else if (wr) begin
            if (!allowed) begin
                bad     = 1'b1;
                stage_d = KS_IDLE;
            end else if (stage_q == KS_IDLE) begin
                if (wdata == KEY_A) stage_d = KS_HALF;
                else                bad     = 1'b1;
            end else begin
                stage_d = KS_IDLE;
                if (wdata == KEY_B) unlock = 1'b1;
                else                bad    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= KS_IDLE;
        else     stage_q <= stage_d;
    end

endmodule

// File: rtl/flk_ctrl_state.sv
module flk_ctrl_state
    import flk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_wr,
    input  logic [NUM_LOCKS-1:0] set_bits,
    input  logic                 prog_bit,
    input  logic                 erase_bit,
    input  logic [NUM_LOCKS-1:0] unlock,
    input  logic                 bad_key,
    input  logic                 busy,
    output ctrl_state_t          st
);

    ctrl_state_t nxt;

    always_comb begin
        nxt = st;
        if (!st.frozen) begin
            for (int i = 0; i < NUM_LOCKS; i++) begin
                if (unlock[i]) nxt.locks[i] = 1'b0;
            end
        end
        if (ctrl_wr) begin
            if (set_bits[LK_CTRL]) begin
                nxt.locks = '1;
            end
            for (int i = 1; i < NUM_LOCKS; i++) begin
                if (set_bits[i]) nxt.locks[i] = 1'b1;
            end
            if (!st.locks[LK_CTRL] && !busy) begin
                nxt.prog  = prog_bit;
                nxt.erase = erase_bit;
            end
        end
        if (bad_key) begin
            nxt.locks  = '1;
            nxt.frozen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.locks  <= '1;
            st.prog   <= 1'b0;
            st.erase  <= 1'b0;
            st.frozen <= 1'b0;
        end else begin
            st <= nxt;
        end
    end

endmodule

// File: rtl/flk_busy_timer.sv
module flk_busy_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic start_pulse
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            start_pulse <= 1'b0;
            cnt_q       <= '0;
        end else begin
            start_pulse <= start && !busy;
            if (start && !busy) begin
                busy  <= 1'b1;
                cnt_q <= CNT_W'(CYCLES - 1);
            end else if (busy) begin
                if (cnt_q == '0) busy  <= 1'b0;
                else             cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/flk_lock_ctrl.sv
module flk_lock_ctrl
    import flk_pkg::*;
#(
    parameter  int ADDR_W       = 16,
    parameter  int PAGE_BYTES   = 256,
    parameter  int ERASE_CYCLES = 20,
    localparam int PAGE_LSB     = $clog2(PAGE_BYTES),
    localparam int PAGE_W       = ADDR_W - PAGE_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_mem,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              erase_start,
    output logic [PAGE_W-1:0] erase_page,
    output logic              busy
);

    ctrl_state_t          st;
    reg_sel_e             sel;
    logic                 reg_ok;
    logic [NUM_LOCKS-1:0] key_wr, key_ok, unlock_v, bad_v;
    logic                 ctrl_wr, erase_go;
    logic [NUM_LOCKS-1:0] locks_w;
    logic                 prog_w, erase_w, frozen_w;

    assign sel      = decode_reg(bus_addr[OFS_W-1:0]);
    assign reg_ok   = !bus_mem && (bus_addr[ADDR_W-1:OFS_W] == '0);
    assign ctrl_wr  = bus_wr && reg_ok && (sel == SEL_CTRL);
    assign locks_w  = st.locks;
    assign prog_w   = st.prog;
    assign erase_w  = st.erase;
    assign frozen_w = st.frozen;

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_key
        assign key_wr[g] = bus_wr && reg_ok && (sel == key_sel(g));
        if (g == LK_CTRL) begin : g_root
            assign key_ok[g] = 1'b1;
        end else begin : g_child
            assign key_ok[g] = !st.locks[LK_CTRL];
        end
        flk_key_seq #(
            .KEY_A(key_first(g)),
            .KEY_B(key_second(g))
        ) u_seq (
            .clk    (clk),
            .rst    (rst),
            .wr     (key_wr[g]),
            .allowed(key_ok[g]),
            .frozen (st.frozen),
            .wdata  (bus_wdata),
            .unlock (unlock_v[g]),
            .bad    (bad_v[g])
        );
    end

    flk_ctrl_state u_state (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .set_bits (bus_wdata[NUM_LOCKS-1:0]),
        .prog_bit (bus_wdata[BIT_PROG]),
        .erase_bit(bus_wdata[BIT_ERASE]),
        .unlock   (unlock_v),
        .bad_key  (|bad_v),
        .busy     (busy),
        .st       (st)
    );

    assign erase_go = bus_wr && bus_mem && (bus_wdata == '0) && st.prog &&
                      st.erase && !st.locks[LK_PROG] && !busy;

    flk_busy_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start      (erase_go),
        .busy       (busy),
        .start_pulse(erase_start)
    );

    always_ff @(posedge clk) begin
        if (rst)           erase_page <= '0;
        else if (erase_go) erase_page <= bus_addr[ADDR_W-1:PAGE_LSB];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && reg_ok) begin
            case (sel)
                SEL_CTRL: begin
                    bus_rdata[NUM_LOCKS-1:0] = st.locks;
                    bus_rdata[BIT_PROG]      = st.prog;
                    bus_rdata[BIT_ERASE]     = st.erase;
                end
                SEL_STAT: bus_rdata[BIT_BUSY] = busy;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/flk_lock_ctrl_chk.sv
module flk_lock_ctrl_chk #(
    parameter int ERASE_CYCLES = 20
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] locks,
    input logic       prog,
    input logic       erase,
    input logic       frozen,
    input logic       busy,
    input logic       erase_start
);

    int busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (locks == 3'b111 && !prog && !erase && !busy)); // R1

    AST_LOCK_ORDER: assert property (@(posedge clk) disable iff (rst)
        locks[0] |-> (locks[2:1] == 2'b11)); // R3

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        frozen |=> (frozen && locks == 3'b111)); // R5

    AST_MODE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable({prog, erase})); // R7

    AST_ERASE_GATE: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> $past(!locks[1] && prog && erase && !busy)); // R8

    AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> erase_start); // R10

    always_ff @(posedge clk) begin
        if (!rst) begin
            AST_BUSY_LEN: assert (busy_run <= ERASE_CYCLES)
                else $error("busy longer than allowed"); // R10
        end
    end

endmodule

bind flk_lock_ctrl flk_lock_ctrl_chk #(.ERASE_CYCLES(ERASE_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .locks      (locks_w),
    .prog       (prog_w),
    .erase      (erase_w),
    .frozen     (frozen_w),
    .busy       (busy),
    .erase_start(erase_start)
);

// File: tb/tb_flk_lock_ctrl.sv
`timescale 1ns/1ps
module tb_flk_lock_ctrl;

    localparam int ADDR_W = 16;
    localparam int NCYC   = 8;
    localparam int PAGE_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0, bus_rd = 1'b0, bus_mem = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              erase_start, busy;
    logic [PAGE_W-1:0] erase_page;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flk_lock_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(256), .ERASE_CYCLES(NCYC)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_mem(bus_mem),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .erase_start(erase_start), .erase_page(erase_page), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic mem, input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_mem = mem; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_mem = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    task automatic unlock_ctrl(); wr(0, 16'h0C, 32'h89AB_CDEF); wr(0, 16'h0C, 32'h0203_0405); endtask
    task automatic unlock_prog(); wr(0, 16'h10, 32'h8C9D_AEBF); wr(0, 16'h10, 32'h1314_1516); endtask
    task automatic unlock_opt();  wr(0, 16'h14, 32'hFBEA_D9C8); wr(0, 16'h14, 32'h2425_2627); endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd(16'h04, v); check("R1 ctrl after reset", v, 32'h7);
        rd(16'h18, v); check("R1 status after reset", v, 32'h0);
        check("R1 busy pin", {31'b0, busy}, 32'h0);
    endtask

    task automatic t_unlock_chain();
        logic [31:0] v;
        do_reset();
        unlock_ctrl(); rd(16'h04, v); check("R2 control lock opened", v, 32'h6);
        rd(16'h0C, v); check("R2 key register reads zero", v, 32'h0);
        unlock_prog(); rd(16'h04, v); check("R3 program lock opened", v, 32'h4);
        unlock_opt();  rd(16'h04, v); check("R4 option lock opened", v, 32'h0);
    endtask

    task automatic t_relock();
        logic [31:0] v;
        do_reset(); unlock_ctrl(); unlock_prog(); unlock_opt();
        wr(0, 16'h04, 32'h0); rd(16'h04, v); check("R6 zero write keeps locks open", v, 32'h0);
        wr(0, 16'h04, 32'h4); rd(16'h04, v); check("R6 bit2 sets only option lock", v, 32'h4);
        wr(0, 16'h04, 32'h1); rd(16'h04, v); check("R6 bit0 sets all locks", v, 32'h7);
    endtask

    task automatic t_mode_guard();
        logic [31:0] v;
        do_reset();
        wr(0, 16'h04, 32'h208); rd(16'h04, v); check("R7 modes ignored while locked", v, 32'h7);
        unlock_ctrl();
        wr(0, 16'h04, 32'h208); rd(16'h04, v); check("R7 modes written when open", v, 32'h20E);
    endtask

    task automatic t_bad_key();
        logic [31:0] v;
        do_reset();
        wr(0, 16'h0C, 32'h89AB_CDEF); wr(0, 16'h0C, 32'h1111_1111);
        rd(16'h04, v); check("R5 bad second word keeps locked", v, 32'h7);
        unlock_ctrl(); rd(16'h04, v); check("R5 frozen ignores correct pair", v, 32'h7);
        do_reset();
        unlock_ctrl(); unlock_opt(); wr(0, 16'h14, 32'h2425_2627);
        rd(16'h04, v); check("R5 out of order word freezes", v, 32'h7);
        do_reset();
        unlock_prog(); rd(16'h04, v); check("R3 program key refused while control locked", v, 32'h7);
        unlock_ctrl(); rd(16'h04, v); check("R3 early program key froze block", v, 32'h7);
        do_reset();
        unlock_opt(); unlock_ctrl(); rd(16'h04, v); check("R4 early option key froze block", v, 32'h7);
    endtask

    task automatic t_erase();
        logic [31:0] v;
        int n;
        do_reset(); unlock_ctrl(); unlock_prog();
        wr(0, 16'h04, 32'h208); rd(16'h04, v); check("R7 erase modes set", v, 32'h20C);
        wr(1, 16'h1234, 32'h5);
        check("R9 nonzero word no erase", {31'b0, erase_start}, 32'h0);
        check("R9 nonzero word not busy", {31'b0, busy}, 32'h0);
        wr(1, 16'h1234, 32'h0);
        check("R8 erase pulse", {31'b0, erase_start}, 32'h1);
        check("R8 erase page", {24'b0, erase_page}, 32'h12);
        check("R10 busy pin after erase", {31'b0, busy}, 32'h1);
        rd(16'h18, v); check("R10 status busy bit", v, 32'h1);
        @(negedge clk);
        check("R8 pulse lasts one cycle", {31'b0, erase_start}, 32'h0);
        wr(0, 16'h04, 32'h0); rd(16'h04, v); check("R7 modes held while busy", v, 32'h20C);
        wr(1, 16'h5600, 32'h0);
        check("R9 no erase while busy", {31'b0, erase_start}, 32'h0);
        n = 0;
        while (busy && n < 100) begin @(negedge clk); n++; end
        wr(1, 16'hFF00, 32'h0);
        check("R8 second erase page", {24'b0, erase_page}, 32'hFF);
        n = 1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (busy) n++; else break;
        end
        check("R10 busy length", n, NCYC);
        rd(16'h18, v); check("R10 status clear after erase", v, 32'h0);
        wr(0, 16'h04, 32'h20A); rd(16'h04, v); check("R6 bit1 relocks program only", v, 32'h20E);
        wr(1, 16'h0100, 32'h0);
        check("R9 no erase with program lock set", {31'b0, erase_start}, 32'h0);
        check("R9 not busy with program lock set", {31'b0, busy}, 32'h0);
        do_reset(); unlock_ctrl(); unlock_prog();
        wr(0, 16'h04, 32'h8);
        wr(1, 16'h0100, 32'h0);
        check("R9 no erase with erase mode clear", {31'b0, erase_start}, 32'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_unlock_chain();
        t_relock();
        t_mode_guard();
        t_bad_key();
        t_erase();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule